// File: doc/BRIEF.md
# Register-Transfer and Arithmetic Byte Core

This block is a small 8-bit processing core. It fetches opcodes from one byte-wide synchronous memory and executes a narrow instruction subset: register-to-register moves, immediate loads, indirect loads and stores through a register pair, and the add, add-with-carry, subtract and subtract-with-borrow group. The core has seven 8-bit working registers (B, C, D, E, H, L and the accumulator A) and one carry flag. Instructions and data share the same memory. The memory returns read data one cycle after the address is presented, and it takes a write in the cycle that `mem_we` is high.

Operand registers are picked straight from 3-bit opcode fields. One code value stands for the memory byte at the address formed by H (high byte) and L (low byte). A dedicated opcode stops the core. Any opcode outside the subset is skipped as a no-operation. A sequencer runs each instruction as a short chain of states: fetch, decode/execute and an optional operand state. The operand state covers the extra memory read that an immediate byte or a memory source needs.

Top module: `byte_core`

## Requirements
- R1: After reset the program counter is 0000h, so the first fetch reads address 0000h. All seven registers and carry are zero, `mem_we` is low and `halted` is low.
- R2: An opcode 01dddsss copies the operand named by sss into the operand named by ddd. The codes are 000=B, 001=C, 010=D, 011=E, 100=H, 101=L, 111=A.
- R3: Operand code 110 names the memory byte at address {H,L}. It serves as a move source (read) and as a move destination (write of the source register).
- R4: Opcode 76h halts the core. From then on `halted` stays high until reset, no further memory write occurs and no later instruction executes.
- R5: An opcode 00ddd110 is followed by one data byte. That byte is loaded into the operand ddd, and ddd=110 writes it to memory at {H,L}.
- R6: Opcode 02h writes A to memory at {B,C}. Opcode 12h writes A to memory at {D,E}.
- R7: Opcode 0Ah loads A from memory at {B,C}. Opcode 1Ah loads A from memory at {D,E}.
- R8: An opcode 10ooosss with ooo=000 (add), 001 (add with carry), 010 (subtract) or 011 (subtract with borrow) combines A with the operand sss and writes the result to A. For example, 35h-22h=13h and 35h+4Ah=7Fh.
- R9: Add and add-with-carry set carry to the unsigned carry out of bit 7. Subtract and subtract-with-borrow set carry when the minuend is smaller than the subtrahend plus the borrow-in. Add-with-carry adds the carry in, and subtract-with-borrow subtracts it.
- R10: Moves, immediate loads, indirect loads and stores leave carry unchanged.
- R11: Opcodes outside the subset, and moves whose ddd equals sss, change no register and no memory.
- R12: The program counter advances by one for every opcode and immediate byte fetched, so instructions run in address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 16 | Memory address for the read or write of this cycle |
| mem_wdata | output | 8 | Byte written to memory when mem_we is high |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Byte read from the address presented one cycle earlier |
| halted | output | 1 | High while the core is stopped by the halt opcode |

## Verification
Two functions meet in a single cycle when an immediate byte bound for memory arrives. The read data coming back from the opcode stream is driven straight out as write data to {H,L} in that same cycle, so the read return and the store share one memory access slot. The bench provokes this case by loading the immediate byte 5Ah to an address that already holds another value. It judges the result by the captured write address and data. It also reads the byte back into B and uses B as the high address byte of a later store, whose expected address proves that the value read back is the new one.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int CORE_DW = 8;

    // Operand field codes used by the opcode fields
    localparam logic [2:0] LOC_B   = 3'b000;
    localparam logic [2:0] LOC_C   = 3'b001;
    localparam logic [2:0] LOC_D   = 3'b010;
    localparam logic [2:0] LOC_E   = 3'b011;
    localparam logic [2:0] LOC_H   = 3'b100;
    localparam logic [2:0] LOC_L   = 3'b101;
    localparam logic [2:0] LOC_MEM = 3'b110;
    localparam logic [2:0] LOC_A   = 3'b111;

    localparam logic [7:0] OPC_HALT = 8'h76;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_OPER   = 2'd2,
        ST_HALT   = 2'd3
    } seq_t;

    typedef enum logic [2:0] {
        K_NOP  = 3'd0,
        K_MOV  = 3'd1,
        K_MVI  = 3'd2,
        K_STA  = 3'd3,
        K_LDA  = 3'd4,
        K_ALU  = 3'd5,
        K_HALT = 3'd6
    } kind_t;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_ADC = 2'd1,
        ALU_SUB = 2'd2,
        ALU_SBB = 2'd3
    } alu_op_t;

endpackage

// File: rtl/byte_core_decode.sv
module byte_core_decode
    import core_pkg::*;
(
    input  logic [7:0] op_i,
    output kind_t      kind_o,
    output logic [2:0] dst_o,
    output logic [2:0] src_o,
    output alu_op_t    aop_o,
    output logic       pair_de_o
);

    always_comb begin
        dst_o     = op_i[5:3];
        src_o     = op_i[2:0];
        aop_o     = alu_op_t'(op_i[4:3]);
        pair_de_o = op_i[4];
        if (op_i == OPC_HALT) begin
            kind_o = K_HALT;
        end else if (op_i[7:6] == 2'b01) begin
            kind_o = K_MOV;
        end else if (op_i[7:5] == 3'b100) begin
            kind_o = K_ALU;
        end else if (op_i[7:6] == 2'b00 && op_i[2:0] == LOC_MEM) begin
            kind_o = K_MVI;
        end else if (op_i[7:5] == 3'b000 && op_i[3:0] == 4'b0010) begin
            kind_o = K_STA;
        end else if (op_i[7:5] == 3'b000 && op_i[3:0] == 4'b1010) begin
            kind_o = K_LDA;
        end else begin
            kind_o = K_NOP;
        end
    end

endmodule

// File: rtl/byte_core_alu.sv
module byte_core_alu
    import core_pkg::*;
#(
    parameter int DATA_W = CORE_DW
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  alu_op_t           op_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);

    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] a_x;
    logic [EXT_W-1:0] b_x;
    logic [EXT_W-1:0] c_x;
    logic [EXT_W-1:0] sum_x;
    logic             use_cin;

    always_comb begin
        use_cin = (op_i == ALU_ADC) || (op_i == ALU_SBB);
        a_x     = {1'b0, a_i};
        b_x     = {1'b0, b_i};
        c_x     = {{DATA_W{1'b0}}, (use_cin & cin_i)};
        if (op_i == ALU_ADD || op_i == ALU_ADC) begin
            sum_x = a_x + b_x + c_x;
        end else begin
            // top bit of the extended difference is the borrow
            sum_x = a_x - b_x - c_x;
        end
        res_o  = sum_x[DATA_W-1:0];
        cout_o = sum_x[DATA_W];
    end

endmodule

// File: rtl/byte_core_regs.sv
module byte_core_regs
    import core_pkg::*;
#(
    parameter int DATA_W = CORE_DW,
    parameter int SLOTS  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we_i,
    input  logic [2:0]                   waddr_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic [SLOTS-1:0][DATA_W-1:0] regs_o
);

    logic [SLOTS-1:0][DATA_W-1:0] regs_d;
    logic [SLOTS-1:0][DATA_W-1:0] regs_q;

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            if (g == int'(LOC_MEM)) begin : g_hole
                // code 110 is memory, not a register
                assign regs_d[g] = '0;
                assign regs_q[g] = '0;
            end else begin : g_reg
                always_comb begin
                    regs_d[g] = regs_q[g];
                    if (we_i && waddr_i == 3'(g)) begin
                        regs_d[g] = wdata_i;
                    end
                end
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        regs_q[g] <= '0;
                    end else begin
                        regs_q[g] <= regs_d[g];
                    end
                end
            end
        end
    endgenerate

    assign regs_o = regs_q;

    AST_NO_MEM_SLOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (waddr_i != LOC_MEM)); // R3

endmodule

// File: rtl/byte_core.sv
module byte_core
    import core_pkg::*;
#(
    parameter int DATA_W = CORE_DW
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [2*DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                mem_we,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                halted
);

    localparam int ADDR_W = 2 * DATA_W;
    localparam int SLOTS  = 8;

    typedef struct packed {
        seq_t              st;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] ir;
        logic              cy;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic [SLOTS-1:0][DATA_W-1:0] regs;
    logic                         rf_we;
    logic [2:0]                   rf_waddr;
    logic [DATA_W-1:0]            rf_wdata;

    logic [DATA_W-1:0] op_cur;
    kind_t             dec_kind;
    logic [2:0]        dec_dst;
    logic [2:0]        dec_src;
    alu_op_t           dec_aop;
    logic              dec_pair_de;

    logic [DATA_W-1:0] src_val;
    logic [DATA_W-1:0] alu_b;
    logic [DATA_W-1:0] alu_res;
    logic              alu_cout;
    logic [ADDR_W-1:0] addr_hl;
    logic [ADDR_W-1:0] addr_pair;

    // in the decode state the opcode is still on the read bus
    assign op_cur = (state_q.st == ST_DECODE) ? mem_rdata : state_q.ir;

    byte_core_decode i_decode (
        .op_i      (op_cur),
        .kind_o    (dec_kind),
        .dst_o     (dec_dst),
        .src_o     (dec_src),
        .aop_o     (dec_aop),
        .pair_de_o (dec_pair_de)
    );

    byte_core_regs #(
        .DATA_W (DATA_W),
        .SLOTS  (SLOTS)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (rf_we),
        .waddr_i (rf_waddr),
        .wdata_i (rf_wdata),
        .regs_o  (regs)
    );

    assign src_val   = regs[dec_src];
    assign alu_b     = (state_q.st == ST_OPER) ? mem_rdata : src_val;
    assign addr_hl   = {regs[LOC_H], regs[LOC_L]};
    assign addr_pair = dec_pair_de ? {regs[LOC_D], regs[LOC_E]}
                                   : {regs[LOC_B], regs[LOC_C]};

    byte_core_alu #(
        .DATA_W (DATA_W)
    ) i_alu (
        .a_i    (regs[LOC_A]),
        .b_i    (alu_b),
        .cin_i  (state_q.cy),
        .op_i   (dec_aop),
        .res_o  (alu_res),
        .cout_o (alu_cout)
    );

    always_comb begin
        state_d   = state_q;
        mem_addr  = state_q.pc;
        mem_we    = 1'b0;
        mem_wdata = regs[LOC_A];
        rf_we     = 1'b0;
        rf_waddr  = dec_dst;
        rf_wdata  = src_val;

        unique case (state_q.st)
            ST_FETCH: begin
                mem_addr   = state_q.pc;
                state_d.pc = state_q.pc + 1'b1;
                state_d.st = ST_DECODE;
            end

            ST_DECODE: begin
                state_d.ir = mem_rdata;
                state_d.st = ST_FETCH;
                case (dec_kind)
                    K_HALT: begin
                        state_d.st = ST_HALT;
                    end
                    K_MOV: begin
                        if (dec_src == LOC_MEM) begin
                            mem_addr   = addr_hl;
                            state_d.st = ST_OPER;
                        end else if (dec_dst == LOC_MEM) begin
                            mem_addr  = addr_hl;
                            mem_we    = 1'b1;
                            mem_wdata = src_val;
                        end else begin
                            rf_we    = 1'b1;
                            rf_waddr = dec_dst;
                            rf_wdata = src_val;
                        end
                    end
                    K_MVI: begin
                        mem_addr   = state_q.pc;
                        state_d.pc = state_q.pc + 1'b1;
                        state_d.st = ST_OPER;
                    end
                    K_STA: begin
                        mem_addr  = addr_pair;
                        mem_we    = 1'b1;
                        mem_wdata = regs[LOC_A];
                    end
                    K_LDA: begin
                        mem_addr   = addr_pair;
                        state_d.st = ST_OPER;
                    end
                    K_ALU: begin
                        if (dec_src == LOC_MEM) begin
                            mem_addr   = addr_hl;
                            state_d.st = ST_OPER;
                        end else begin
                            rf_we      = 1'b1;
                            rf_waddr   = LOC_A;
                            rf_wdata   = alu_res;
                            state_d.cy = alu_cout;
                        end
                    end
                    default: begin
                    end
                endcase
            end

            ST_OPER: begin
                state_d.st = ST_FETCH;
                case (dec_kind)
                    K_MVI: begin
                        if (dec_dst == LOC_MEM) begin
                            mem_addr  = addr_hl;
                            mem_we    = 1'b1;
                            mem_wdata = mem_rdata;
                        end else begin
                            rf_we    = 1'b1;
                            rf_waddr = dec_dst;
                            rf_wdata = mem_rdata;
                        end
                    end
                    K_MOV: begin
                        rf_we    = 1'b1;
                        rf_waddr = dec_dst;
                        rf_wdata = mem_rdata;
                    end
                    K_LDA: begin
                        rf_we    = 1'b1;
                        rf_waddr = LOC_A;
                        rf_wdata = mem_rdata;
                    end
                    K_ALU: begin
                        rf_we      = 1'b1;
                        rf_waddr   = LOC_A;
                        rf_wdata   = alu_res;
                        state_d.cy = alu_cout;
                    end
                    default: begin
                    end
                endcase
            end

            ST_HALT: begin
                state_d.st = ST_HALT;
            end

            default: begin
                state_d.st = ST_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{st: ST_FETCH, pc: '0, ir: '0, cy: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign halted = (state_q.st == ST_HALT);

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R4
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we); // R4
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == ST_FETCH) |=> (state_q.pc == $past(state_q.pc) + 1'b1)); // R12
    AST_CARRY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_kind != K_ALU) |=> $stable(state_q.cy)); // R10
    AST_NO_WRITE_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state_q.st != ST_FETCH)); // R6

endmodule

// File: tb/test_byte_core.sv
module test_byte_core;

    localparam int CLK_NS = 10;
    localparam int RUN_LIMIT = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata = 8'h00;
    logic        halted;

    always #(CLK_NS / 2) clk = ~clk;

    byte_core i_byte_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    logic [7:0] mem [int];

    function automatic logic [7:0] rd(input logic [15:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 8'h00;
    endfunction

    // memory model: one-cycle read latency, write at the edge
    always @(posedge clk) begin
        mem_rdata <= rd(mem_addr);
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    end

    typedef struct {
        logic [15:0] a;
        logic [7:0]  d;
        string       tag;
    } wr_t;

    wr_t exp_q[$];
    int  checks = 0;
    int  fails = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // monitor: pops the scoreboard on every observed write
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4", "unexpected write addr", {16'h0, mem_addr}, 32'h0);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                check(mem_addr == e.a, e.tag, "write address", {16'h0, mem_addr}, {16'h0, e.a});
                check(mem_wdata == e.d, e.tag, "write data", {24'h0, mem_wdata}, {24'h0, e.d});
            end
        end
    end

    task automatic load(input logic [7:0] prog[$]);
        mem.delete();
        for (int i = 0; i < prog.size(); i++) mem[i] = prog[i];
    endtask

    task automatic expect_wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        wr_t e;
        e.a = a;
        e.d = d;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic run_prog();
        int n;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state at the ports
        check(mem_addr == 16'h0000, "R1", "reset fetch address", {16'h0, mem_addr}, 32'h0);
        check(mem_we == 1'b0, "R1", "reset write strobe", {31'h0, mem_we}, 32'h0);
        check(halted == 1'b0, "R1", "reset halted", {31'h0, halted}, 32'h0);
        rst_n = 1'b1;
        n = 0;
        while (!halted && n < RUN_LIMIT) begin
            @(negedge clk);
            n++;
        end
        check(halted == 1'b1, "R4", "halted after program", {31'h0, halted}, 32'h1);
        repeat (8) @(negedge clk);
        check(halted == 1'b1, "R4", "halted held", {31'h0, halted}, 32'h1);
        check(exp_q.size() == 0, "R12", "writes outstanding", exp_q.size(), 32'h0);
        exp_q.delete();
    endtask

    logic [7:0] p1[$];
    logic [7:0] p2[$];
    logic [7:0] p3[$];

    initial begin
        #(CLK_NS * 150000);
        check(1'b0, "R12", "watchdog expired", 32'h1, 32'h0);
        summary();
        $finish;
    end

    initial begin
        // Program 1: reset contents of A, BC, DE and carry (R1)
        p1 = '{8'h02, 8'h88, 8'h12, 8'h76};
        load(p1);
        expect_wr(16'h0000, 8'h00, "R1");   // A=0 at BC=0
        expect_wr(16'h0000, 8'h00, "R1");   // ADC with B=0, carry=0
        run_prog();

        // Program 2: moves, memory operand, immediates, pair access, no-ops
        p2 = '{8'h06, 8'h35, 8'h26, 8'h10, 8'h2E, 8'h7C,
               8'h78, 8'h86, 8'h57, 8'h72,
               8'h3E, 8'h35, 8'h0E, 8'h22, 8'h91, 8'h77,
               8'h5B, 8'h49,
               8'h36, 8'h5A, 8'h46, 8'h02,
               8'h16, 8'h20, 8'h1E, 8'h00, 8'h1A, 8'h77, 8'h12,
               8'h00, 8'h07, 8'hFF, 8'hC3, 8'h77,
               8'h76, 8'h77};
        load(p2);
        mem[16'h107C] = 8'h4A;
        mem[16'h2000] = 8'hC3;
        expect_wr(16'h107C, 8'h7F, "R2");   // A=B, A+=mem[HL], D=A, store D via code 110
        expect_wr(16'h107C, 8'h13, "R8");   // 35h-22h
        expect_wr(16'h107C, 8'h5A, "R5");   // immediate to memory at HL
        expect_wr(16'h5A22, 8'h13, "R3");   // B loaded from memory at HL, used via BC
        expect_wr(16'h107C, 8'hC3, "R7");   // A loaded through DE
        expect_wr(16'h2000, 8'hC3, "R6");   // A stored through DE
        expect_wr(16'h107C, 8'hC3, "R11");  // unsupported opcodes left A alone
        run_prog();

        // Program 3: carry chain and borrow corners
        p3 = '{8'h06, 8'h01, 8'h0E, 8'hF0, 8'h16, 8'h02, 8'h1E, 8'h30,
               8'h79, 8'h83, 8'h4F, 8'h78, 8'h8A, 8'h47,
               8'h26, 8'h30, 8'h2E, 8'h00, 8'h70, 8'h2E, 8'h01, 8'h71,
               8'h3E, 8'h05, 8'h06, 8'h07, 8'h90, 8'h2E, 8'h02, 8'h77,
               8'h3E, 8'h09, 8'h98, 8'h2E, 8'h03, 8'h77,
               8'h3E, 8'h00, 8'h0E, 8'h01, 8'h91, 8'h3E, 8'h07, 8'h98,
               8'h2E, 8'h04, 8'h77,
               8'h3E, 8'h00, 8'h8F, 8'h2E, 8'h05, 8'h77,
               8'h3E, 8'hFF, 8'h81, 8'h2E, 8'h06, 8'h77,
               8'h8F, 8'h2E, 8'h07, 8'h77,
               8'h76};
        load(p3);
        expect_wr(16'h3000, 8'h04, "R10");  // carry from F0h+30h kept across moves into ADC
        expect_wr(16'h3001, 8'h20, "R9");   // low byte of 01F0h+0230h
        expect_wr(16'h3002, 8'hFE, "R9");   // 05h-07h with borrow out
        expect_wr(16'h3003, 8'h01, "R9");   // 09h-07h-1 via borrow in
        expect_wr(16'h3004, 8'hFF, "R9");   // 07h-07h-1 borrows again
        expect_wr(16'h3005, 8'h01, "R9");   // borrow seen as carry by ADC
        expect_wr(16'h3006, 8'h00, "R9");   // FFh+01h wraps with carry
        expect_wr(16'h3007, 8'h01, "R9");   // carry from wrap added by ADC
        run_prog();

        summary();
        $finish;
    end

endmodule